// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block decides whether a frequency-synthesis loop has settled. Once per phase-detector cycle the surrounding logic gives it a sample strobe, together with a flag saying whether the measured phase error was smaller than one reference-clock period. The detector keeps a run counter of consecutive samples that point away from its current verdict. It changes its verdict only when that run is long enough. Acquiring lock takes a long run of small errors. Losing lock takes a shorter run of large errors, so a single glitch neither grants nor revokes lock.

A precision input selects one of two threshold pairs. Writing a new frequency setting forces the unlocked state. Writing the function register restarts the run without changing the verdict. A 3-bit select code routes either the filtered verdict or the raw phase-comparison signal to the lock pin, and any other code holds the pin low.

Top module: `lock_hyst_detect`

## Requirements
- R1: A frequency-write pulse makes `locked` 0 and empties the run at the next clock edge, and it takes priority over a sample arriving in the same cycle.
- R2: While unlocked, each valid sample with `err_small`=1 extends the run, and each valid sample with `err_small`=0 empties it. `locked` rises at the edge of the sample that makes the run one longer than the acquire threshold.
- R3: While locked, each valid sample with `err_small`=0 extends the run, and each valid sample with `err_small`=1 empties it. `locked` falls at the edge of the sample that makes the run one longer than the release threshold.
- R4: With `prec_long`=0 the acquire and release thresholds are 15 and 3, so 16 and 4 consecutive samples are needed. With `prec_long`=1 they are 31 and 7, so 32 and 8 samples are needed.
- R5: With `pin_sel`=3'b001, `lock_pin` follows `locked`. With `pin_sel`=3'b101, `lock_pin` follows `raw_cmp` in the same cycle.
- R6: Cycles with `smp_valid`=0 change neither the run nor the verdict, whatever `err_small` shows.
- R7: A function-write pulse empties the run and leaves `locked` unchanged. The run also empties whenever the verdict changes.
- R8: Any `pin_sel` code other than 3'b001 and 3'b101 drives `lock_pin` low.
- R9: After reset the block is unlocked with an empty run, so `lock_pin` is 0 for every select code except 3'b101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a usable phase-error sample |
| err_small | input | 1 | 1 when the sampled phase error is below one reference period |
| raw_cmp | input | 1 | Unfiltered phase-comparison signal |
| prec_long | input | 1 | Threshold pair select (0: 15/3, 1: 31/7) |
| pin_sel | input | 3 | Lock pin source code |
| freq_wr | input | 1 | Pulse on each new frequency setting |
| func_wr | input | 1 | Pulse on each function register write |
| locked | output | 1 | Filtered lock verdict |
| lock_pin | output | 1 | Lock-detect pin value |

## Verification
The bench builds the block with its default parameters: threshold pairs 15/3 and 31/7, a 5-bit run counter and a combinational pin path. This exposes both threshold pairs exactly at their boundaries, one sample short of and exactly at each switch point. A run that has reached 31 can still be frozen by invalid cycles and then completed. Runs are split by function writes and by frequency writes, so the bench can show that those pulses restart the count rather than merely pausing it.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_FILT = 2'd1,
      SRC_RAW  = 2'd2
   } pin_src_e;

   function automatic pin_src_e decode_src(input logic [7:0] sel,
                                           input logic [7:0] code_filt,
                                           input logic [7:0] code_raw);
      if (sel == code_filt)     return SRC_FILT;
      else if (sel == code_raw) return SRC_RAW;
      else                      return SRC_ZERO;
   endfunction
endpackage

// File: rtl/lkd_thresh.sv
module lkd_thresh #(
   parameter int CNT_W      = 5,
   parameter int ACQ_SHORT  = 15,
   parameter int REL_SHORT  = 3,
   parameter int ACQ_LONG   = 31,
   parameter int REL_LONG   = 7
) (
   input  logic             prec_long,
   input  logic             locked,
   output logic [CNT_W-1:0] thr
);
   localparam logic [CNT_W-1:0] A_S = CNT_W'(ACQ_SHORT);
   localparam logic [CNT_W-1:0] R_S = CNT_W'(REL_SHORT);
   localparam logic [CNT_W-1:0] A_L = CNT_W'(ACQ_LONG);
   localparam logic [CNT_W-1:0] R_L = CNT_W'(REL_LONG);

   always_comb begin
      unique case ({locked, prec_long})
         2'b00:   thr = A_S;
         2'b01:   thr = A_L;
         2'b10:   thr = R_S;
         default: thr = R_L;
      endcase
   end
endmodule

// File: rtl/lkd_run_ctr.sv
module lkd_run_ctr #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (clr)                     cnt <= '0;
      else if (inc && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/lkd_state.sv
module lkd_state (
   input  logic clk,
   input  logic rst_n,
   input  logic force_unlock,
   input  logic flip,
   output logic locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            locked <= 1'b0;
      else if (force_unlock) locked <= 1'b0;
      else if (flip)         locked <= ~locked;
   end
endmodule

// File: rtl/lkd_pin_mux.sv
module lkd_pin_mux
   import lkd_pkg::*;
#(
   parameter int          SEL_W     = 3,
   parameter logic [7:0]  CODE_FILT = 8'd1,
   parameter logic [7:0]  CODE_RAW  = 8'd5,
   parameter bit          REG_OUT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             locked,
   input  logic             raw_cmp,
   output logic             pin
);
   pin_src_e src;
   logic     pin_d;

   assign src = decode_src(8'(sel), CODE_FILT, CODE_RAW);

   always_comb begin
      unique case (src)
         SRC_FILT: pin_d = locked;
         SRC_RAW:  pin_d = raw_cmp;
         default:  pin_d = 1'b0;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin <= 1'b0;
            else        pin <= pin_d;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign pin = pin_d;
      end
   endgenerate
endmodule

// File: rtl/lock_hyst_detect.sv
module lock_hyst_detect #(
   parameter int         ACQ_SHORT = 15,
   parameter int         REL_SHORT = 3,
   parameter int         ACQ_LONG  = 31,
   parameter int         REL_LONG  = 7,
   parameter int         SEL_W     = 3,
   parameter logic [7:0] CODE_FILT = 8'd1,
   parameter logic [7:0] CODE_RAW  = 8'd5,
   parameter bit         REG_OUT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic             err_small,
   input  logic             raw_cmp,
   input  logic             prec_long,
   input  logic [SEL_W-1:0] pin_sel,
   input  logic             freq_wr,
   input  logic             func_wr,
   output logic             locked,
   output logic             lock_pin
);
   localparam int MAX_THR = (ACQ_LONG > ACQ_SHORT) ? ACQ_LONG : ACQ_SHORT;
   localparam int CNT_W   = $clog2(MAX_THR + 1);

   generate
      if (REL_SHORT >= ACQ_SHORT || REL_LONG >= ACQ_LONG) begin : g_bad_hyst
         $error("release thresholds must be below acquire thresholds");
      end
      if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel
         $error("SEL_W must be 1..8");
      end
      if (CODE_FILT == CODE_RAW) begin : g_bad_code
         $error("pin source codes must differ");
      end
   endgenerate

   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] thr;
   logic             agree;
   logic             extend;
   logic             hit;
   logic             clr;

   // A sample "agrees" with a verdict change when it argues against the current state.
   assign agree  = locked ? ~err_small : err_small;
   assign extend = smp_valid & agree & ~freq_wr & ~func_wr;
   assign hit    = extend & (run_cnt >= thr);
   assign clr    = freq_wr | func_wr | hit | (smp_valid & ~agree);

   lkd_thresh #(
      .CNT_W(CNT_W), .ACQ_SHORT(ACQ_SHORT), .REL_SHORT(REL_SHORT),
      .ACQ_LONG(ACQ_LONG), .REL_LONG(REL_LONG)
   ) u_thresh (
      .prec_long(prec_long), .locked(locked), .thr(thr)
   );

   lkd_run_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(extend), .cnt(run_cnt)
   );

   lkd_state u_state (
      .clk(clk), .rst_n(rst_n), .force_unlock(freq_wr), .flip(hit), .locked(locked)
   );

   lkd_pin_mux #(
      .SEL_W(SEL_W), .CODE_FILT(CODE_FILT), .CODE_RAW(CODE_RAW), .REG_OUT(REG_OUT)
   ) u_mux (
      .clk(clk), .rst_n(rst_n), .sel(pin_sel), .locked(locked),
      .raw_cmp(raw_cmp), .pin(lock_pin)
   );
endmodule

// File: rtl/lkd_checker.sv
module lkd_checker #(
   parameter int         CNT_W     = 5,
   parameter int         ACQ_SHORT = 15,
   parameter int         REL_SHORT = 3,
   parameter int         ACQ_LONG  = 31,
   parameter int         REL_LONG  = 7,
   parameter int         SEL_W     = 3,
   parameter logic [7:0] CODE_FILT = 8'd1,
   parameter logic [7:0] CODE_RAW  = 8'd5,
   parameter bit         REG_OUT   = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic             err_small,
   input logic             prec_long,
   input logic [SEL_W-1:0] pin_sel,
   input logic             freq_wr,
   input logic             func_wr,
   input logic             locked,
   input logic             lock_pin,
   input logic [CNT_W-1:0] run_cnt
);
   AST_FREQ_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      freq_wr |=> (!locked && run_cnt == '0));  // R1

   AST_ACQ_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> ($past(smp_valid && err_small) &&
         int'($past(run_cnt)) == ($past(prec_long) ? ACQ_LONG : ACQ_SHORT)));  // R2

   AST_REL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(locked) && !$past(freq_wr)) |-> ($past(smp_valid && !err_small) &&
         int'($past(run_cnt)) == ($past(prec_long) ? REL_LONG : REL_SHORT)));  // R3

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && !freq_wr && !func_wr) |=> ($stable(locked) && $stable(run_cnt)));  // R6

   AST_FUNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (func_wr && !freq_wr) |=> (run_cnt == '0 && $stable(locked)));  // R7

   AST_FLIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (locked != $past(locked)) |-> run_cnt == '0);  // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(run_cnt) <= ((ACQ_LONG > ACQ_SHORT) ? ACQ_LONG : ACQ_SHORT));  // R2

   generate
      if (!REG_OUT) begin : g_pin_chk
         AST_PIN_FILT: assert property (@(posedge clk) disable iff (!rst_n)
            (8'(pin_sel) == CODE_FILT) |-> lock_pin == locked);  // R5

         AST_PIN_OTHER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (8'(pin_sel) != CODE_FILT && 8'(pin_sel) != CODE_RAW) |-> !lock_pin);  // R8
      end
   endgenerate
endmodule

bind lock_hyst_detect lkd_checker #(
   .CNT_W(CNT_W), .ACQ_SHORT(ACQ_SHORT), .REL_SHORT(REL_SHORT),
   .ACQ_LONG(ACQ_LONG), .REL_LONG(REL_LONG), .SEL_W(SEL_W),
   .CODE_FILT(CODE_FILT), .CODE_RAW(CODE_RAW), .REG_OUT(REG_OUT)
) u_lkd_checker (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .err_small(err_small),
   .prec_long(prec_long), .pin_sel(pin_sel), .freq_wr(freq_wr), .func_wr(func_wr),
   .locked(locked), .lock_pin(lock_pin), .run_cnt(run_cnt)
);

// File: tb/lock_hyst_detect_bench.sv
module lock_hyst_detect_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_valid = 1'b0;
   logic       err_small = 1'b1;
   logic       raw_cmp = 1'b0;
   logic       prec_long = 1'b0;
   logic [2:0] pin_sel = 3'b001;
   logic       freq_wr = 1'b0;
   logic       func_wr = 1'b0;
   logic       locked;
   logic       lock_pin;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   lock_hyst_detect u_lock_hyst_detect (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .err_small(err_small),
      .raw_cmp(raw_cmp), .prec_long(prec_long), .pin_sel(pin_sel),
      .freq_wr(freq_wr), .func_wr(func_wr), .locked(locked), .lock_pin(lock_pin)
   );

   // Row: kind[12:10] len[9:2] prec[1] expected_locked[0]
   // kind 0 small-error sample, 1 large-error sample, 2 invalid cycle,
   //      3 frequency write, 4 function write
   localparam logic [12:0] VEC [0:29] = '{
      {3'd0, 8'd15, 1'b0, 1'b0},  // R2 one short of acquire
      {3'd0, 8'd1,  1'b0, 1'b1},  // R2 R4 16th small locks
      {3'd1, 8'd3,  1'b0, 1'b1},  // R3 three large not enough
      {3'd0, 8'd1,  1'b0, 1'b1},  // R3 small empties run
      {3'd1, 8'd3,  1'b0, 1'b1},  // R3
      {3'd1, 8'd1,  1'b0, 1'b0},  // R3 R4 4th large unlocks
      {3'd0, 8'd10, 1'b0, 1'b0},  // R2
      {3'd1, 8'd1,  1'b0, 1'b0},  // R2 large empties run
      {3'd0, 8'd15, 1'b0, 1'b0},  // R2
      {3'd0, 8'd1,  1'b0, 1'b1},  // R2
      {3'd3, 8'd1,  1'b1, 1'b0},  // R1 frequency write unlocks
      {3'd0, 8'd31, 1'b1, 1'b0},  // R4 31 small not enough
      {3'd2, 8'd5,  1'b1, 1'b0},  // R6 invalid cycles freeze run
      {3'd0, 8'd1,  1'b1, 1'b1},  // R4 R6 32nd small locks
      {3'd1, 8'd7,  1'b1, 1'b1},  // R4 seven large not enough
      {3'd2, 8'd3,  1'b1, 1'b1},  // R6
      {3'd1, 8'd1,  1'b1, 1'b0},  // R4 R6 8th large unlocks
      {3'd0, 8'd20, 1'b1, 1'b0},  // R7
      {3'd4, 8'd1,  1'b1, 1'b0},  // R7 function write, state kept
      {3'd0, 8'd31, 1'b1, 1'b0},  // R7 run restarted from zero
      {3'd0, 8'd1,  1'b1, 1'b1},  // R7
      {3'd1, 8'd2,  1'b1, 1'b1},  // R3
      {3'd4, 8'd1,  1'b1, 1'b1},  // R7 function write keeps lock
      {3'd1, 8'd6,  1'b1, 1'b1},  // R7 6 after clear not enough
      {3'd1, 8'd2,  1'b1, 1'b0},  // R7 8 after clear unlocks
      {3'd0, 8'd10, 1'b0, 1'b0},  // R2
      {3'd3, 8'd1,  1'b0, 1'b0},  // R1 frequency write empties run
      {3'd0, 8'd6,  1'b0, 1'b0},  // R1 10+6 would have locked
      {3'd0, 8'd9,  1'b0, 1'b0},  // R1 15 since write
      {3'd0, 8'd1,  1'b0, 1'b1}   // R1 16 since write
   };

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle_inputs();
      smp_valid = 1'b0;
      err_small = 1'b1;
      freq_wr   = 1'b0;
      func_wr   = 1'b0;
   endtask

   task automatic apply_row(input logic [2:0] kind, input int len, input logic prec);
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         idle_inputs();
         prec_long = prec;
         case (kind)
            3'd0: begin smp_valid = 1'b1; err_small = 1'b1; end
            3'd1: begin smp_valid = 1'b1; err_small = 1'b0; end
            3'd2: begin smp_valid = 1'b0; err_small = 1'b0; end
            3'd3: freq_wr = 1'b1;
            default: func_wr = 1'b1;
         endcase
      end
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset locked", locked, 1'b0);
      check("R9 reset pin", lock_pin, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 after reset locked", locked, 1'b0);
      check("R9 after reset pin", lock_pin, 1'b0);

      for (int i = 0; i < 30; i++) begin
         apply_row(VEC[i][12:10], int'(VEC[i][9:2]), VEC[i][1]);
         check($sformatf("row %0d locked (R1..R7)", i), locked, VEC[i][0]);
         check($sformatf("row %0d pin R5", i), lock_pin, VEC[i][0]);
      end

      // now locked=1; pin source selection
      pin_sel = 3'b101; raw_cmp = 1'b0; #1;
      check("R5 raw path low", lock_pin, 1'b0);
      raw_cmp = 1'b1; #1;
      check("R5 raw path high", lock_pin, 1'b1);
      pin_sel = 3'b000; #1;
      check("R8 code 000 low", lock_pin, 1'b0);
      pin_sel = 3'b111; #1;
      check("R8 code 111 low", lock_pin, 1'b0);
      pin_sel = 3'b011; #1;
      check("R8 code 011 low", lock_pin, 1'b0);
      pin_sel = 3'b001; raw_cmp = 1'b0; #1;
      check("R5 filtered path", lock_pin, 1'b1);

      // frequency write coinciding with the deciding sample
      apply_row(3'd3, 1, 1'b0);
      check("R1 write unlocks", locked, 1'b0);
      apply_row(3'd0, 15, 1'b0);
      @(negedge clk);
      smp_valid = 1'b1; err_small = 1'b1; freq_wr = 1'b1;
      @(negedge clk);
      idle_inputs();
      check("R1 write beats deciding sample", locked, 1'b0);
      apply_row(3'd0, 15, 1'b0);
      check("R1 15 after write", locked, 1'b0);
      apply_row(3'd0, 1, 1'b0);
      check("R2 16 after write", locked, 1'b1);

      // reset in the middle of a locked state
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 reset clears lock", locked, 1'b0);
      rst_n = 1'b1;
      apply_row(3'd0, 15, 1'b0);
      check("R9 run empty after reset", locked, 1'b0);

      finish_run();
   end
endmodule